// File: doc/BRIEF.md
# Per-Port Packet Framing Guard

This block sits on the write side of a shared transmit queue. Every incoming word carries an 8-bit port tag, a start flag and an end flag. For each checked port the guard records whether a packet is currently open. It compares each word's flags against that record and repairs bad framing in-line, so the queue only ever receives well-formed packets. Each repair also raises a one-cycle error strobe with a 2-bit cause code, which upstream logic can log or count.

Words are presented with a valid/ready pair and come out one cycle later. The guard holds ready low for exactly one cycle, and only when it has to insert a closing marker word ahead of an unexpected start. Port tags at or above the `NPORTS` parameter are forwarded untouched and never checked. With `CHECK_EN` cleared the block is a plain one-cycle register stage. The tag is always 8 bits wide and is never altered.

Top module: `frame_guard`

## Requirements
- R1: A synchronous reset clears every per-port open record and the held word. During reset and on the first cycle after it, out_valid and err_stb are low and in_ready is high, so a word without a start flag on a checked port is then treated as a missing start.
- R2: A word accepted (in_valid and in_ready high) on a rising edge appears on the outputs after that same edge, with data and port unchanged. A correctly framed word gives no error strobe and out_empty low.
- R3: A word on a checked port with no packet open, with both start and end flags low, is forwarded with out_sop forced to 1. It raises err_stb with err_code 0, and the port becomes open.
- R4: A start on a checked port that already has a packet open causes a two-cycle repair. In the first cycle the guard emits a zero-length marker word: out_valid 1, out_empty 1, out_eop 1, out_sop 0, data all zeros, same port, err_code 2. In that cycle in_ready is 0. In the next cycle the original word is emitted with out_sop 1, its own end flag, and err_code 1.
- R5: An end flag without a start flag on a checked port with no packet open is dropped. out_valid stays low, err_stb is raised with err_code 3, and the port stays closed.
- R6: Open records are kept per port. A start sets the port's record, an end clears it, and a word carrying both flags leaves it closed. Words from different ports may interleave freely without affecting each other.
- R7: Words whose port tag is at or above NPORTS are forwarded with all flags and data unchanged, never raise err_stb, and never change any open record.
- R8: With CHECK_EN = 0, every word is forwarded one cycle later exactly as received. in_ready is always 1 and err_stb is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Guard can take a word this cycle |
| in_data | input | DW | Input payload |
| in_port | input | 8 | Input port tag |
| in_sop | input | 1 | Input start-of-packet flag |
| in_eop | input | 1 | Input end-of-packet flag |
| out_valid | output | 1 | Output word present |
| out_data | output | DW | Output payload |
| out_port | output | 8 | Output port tag |
| out_sop | output | 1 | Output start flag (possibly repaired) |
| out_eop | output | 1 | Output end flag (possibly repaired) |
| out_empty | output | 1 | Output word is a zero-length closing marker |
| err_stb | output | 1 | One-cycle framing error strobe |
| err_code | output | 2 | Cause: 0 missing start, 1 repeated start, 2 missing end, 3 lone end |

## Verification
The bench builds two copies of the guard, both with a 16-bit payload and NPORTS = 4. The main copy has checking enabled. The second copy has CHECK_EN = 0 and is fed the same stimulus. Because tags 4 and 5 are also driven, the unchecked-tag path is exercised right next to checked ports in the same stream. The small port count lets random flag patterns reach every open/closed and start/end combination on each port many times, including back-to-back repeated starts that make the guard stall.

// File: rtl/frame_guard.sv
module frame_guard #(
  parameter int DW       = 32,
  parameter int NPORTS   = 16,
  parameter bit CHECK_EN = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic [7:0]    in_port,
  input  logic          in_sop,
  input  logic          in_eop,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic [7:0]    out_port,
  output logic          out_sop,
  output logic          out_eop,
  output logic          out_empty,
  output logic          err_stb,
  output logic [1:0]    err_code
);
  localparam int TAGS = 256;
  localparam logic [8:0] LIMIT = 9'(NPORTS);

  typedef enum logic [1:0] {NO_START = 2'd0, RE_START = 2'd1, NO_END = 2'd2, LONE_END = 2'd3} cause_t;

  logic [TAGS-1:0] open_q;
  logic            hold_q;
  logic [DW-1:0]   hold_data;
  logic [7:0]      hold_port;
  logic            hold_eop;

  wire take    = in_valid && in_ready;
  wire checked = CHECK_EN && ({1'b0, in_port} < LIMIT);
  wire is_open = open_q[in_port];

  assign in_ready = !hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q    <= '0;
      hold_q    <= 1'b0;
      hold_data <= '0;
      hold_port <= '0;
      hold_eop  <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_port  <= '0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      out_empty <= 1'b0;
      err_stb   <= 1'b0;
      err_code  <= '0;
    end else begin
      out_valid <= 1'b0;
      out_empty <= 1'b0;
      err_stb   <= 1'b0;
      if (hold_q) begin
        hold_q            <= 1'b0;
        out_valid         <= 1'b1;
        out_data          <= hold_data;
        out_port          <= hold_port;
        out_sop           <= 1'b1;
        out_eop           <= hold_eop;
        err_stb           <= 1'b1;
        err_code          <= RE_START;
        open_q[hold_port] <= !hold_eop;
      end else if (take) begin
        out_valid <= 1'b1;
        out_data  <= in_data;
        out_port  <= in_port;
        out_sop   <= in_sop;
        out_eop   <= in_eop;
        if (checked) begin
          case ({is_open, in_sop, in_eop})
            3'b000: begin
              out_sop         <= 1'b1;
              err_stb         <= 1'b1;
              err_code        <= NO_START;
              open_q[in_port] <= 1'b1;
            end
            3'b001: begin
              out_valid <= 1'b0;
              out_eop   <= 1'b0;
              err_stb   <= 1'b1;
              err_code  <= LONE_END;
            end
            3'b010, 3'b011: open_q[in_port] <= !in_eop;
            3'b110, 3'b111: begin
              out_data        <= '0;
              out_sop         <= 1'b0;
              out_eop         <= 1'b1;
              out_empty       <= 1'b1;
              err_stb         <= 1'b1;
              err_code        <= NO_END;
              hold_q          <= 1'b1;
              hold_data       <= in_data;
              hold_port       <= in_port;
              hold_eop        <= in_eop;
              open_q[in_port] <= 1'b0;
            end
            default: if (in_eop) open_q[in_port] <= 1'b0;
          endcase
        end
      end
    end
  end
endmodule

module frame_guard_chk #(
  parameter int NPORTS = 16
) (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic [7:0] out_port,
  input logic       out_sop,
  input logic       out_eop,
  input logic       out_empty,
  input logic       err_stb,
  input logic [1:0] err_code
);
  localparam logic [8:0] LIMIT = 9'(NPORTS);

  // R2
  accept_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (out_valid || (err_stb && err_code == 2'd3)));

  // R4
  marker_then_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_empty) |=> (out_valid && out_sop && err_stb && err_code == 2'd1));

  // R4
  marker_stalls_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_empty) |-> (!in_ready && out_eop && !out_sop));

  // R3
  missing_start_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    (err_stb && err_code == 2'd0) |-> (out_valid && out_sop));

  // R5
  lone_end_dropped_chk: assert property (@(posedge clk) disable iff (rst)
    (err_stb && err_code == 2'd3) |-> !out_valid);

  // R7
  unchecked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && ({1'b0, out_port} >= LIMIT)) |-> !err_stb);
endmodule

bind frame_guard frame_guard_chk #(.NPORTS(NPORTS)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_port(out_port), .out_sop(out_sop), .out_eop(out_eop),
  .out_empty(out_empty), .err_stb(err_stb), .err_code(err_code)
);

// File: tb/frame_guard_test.sv
`timescale 1ns/1ps
module frame_guard_test;
  localparam int DW = 16;
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [7:0] in_port = '0;

  logic in_ready, out_valid, out_sop, out_eop, out_empty, err_stb;
  logic [DW-1:0] out_data;
  logic [7:0] out_port;
  logic [1:0] err_code;

  logic p_ready, p_valid, p_sop, p_eop, p_empty, p_err;
  logic [DW-1:0] p_data;
  logic [7:0] p_port;
  logic [1:0] p_code;

  always #4 clk = ~clk;

  frame_guard #(.DW(DW), .NPORTS(NP), .CHECK_EN(1'b1)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_port(in_port), .in_sop(in_sop), .in_eop(in_eop), .out_valid(out_valid),
    .out_data(out_data), .out_port(out_port), .out_sop(out_sop), .out_eop(out_eop),
    .out_empty(out_empty), .err_stb(err_stb), .err_code(err_code));

  frame_guard #(.DW(DW), .NPORTS(NP), .CHECK_EN(1'b0)) uut_pass (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(p_ready), .in_data(in_data),
    .in_port(in_port), .in_sop(in_sop), .in_eop(in_eop), .out_valid(p_valid),
    .out_data(p_data), .out_port(p_port), .out_sop(p_sop), .out_eop(p_eop),
    .out_empty(p_empty), .err_stb(p_err), .err_code(p_code));

  int checks = 0, failures = 0, cycles = 0;
  bit done = 1'b0;

  bit mopen [256];
  bit mhold;
  logic [DW-1:0] mhd;
  logic [7:0] mhp;
  bit mhe;

  bit e_v, e_sop, e_eop, e_empty, e_err, e_ready;
  logic [DW-1:0] e_data;
  logic [7:0] e_port;
  logic [1:0] e_code;
  bit q_v, q_sop, q_eop;
  logic [DW-1:0] q_data;
  logic [7:0] q_port;

  function automatic string tag_of();
    if (e_err) begin
      case (e_code)
        2'd0: return "R3";
        2'd1, 2'd2: return "R4";
        default: return "R5";
      endcase
    end
    if (e_v && e_port >= NP) return "R7";
    return "R2";
  endfunction

  task automatic expect_eq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    string t;
    t = tag_of();
    expect_eq(t, "out_valid", int'(out_valid), int'(e_v));
    expect_eq(t, "err_stb", int'(err_stb), int'(e_err));
    expect_eq("R4", "in_ready", int'(in_ready), int'(e_ready));
    if (e_v) begin
      expect_eq(t, "out_data", int'(out_data), int'(e_data));
      expect_eq(t, "out_port", int'(out_port), int'(e_port));
      expect_eq(t, "sop/eop/empty", int'({out_sop, out_eop, out_empty}), int'({e_sop, e_eop, e_empty}));
    end
    if (e_err) expect_eq(t, "err_code", int'(err_code), int'(e_code));
    // R8: pass-through copy
    expect_eq("R8", "pass ready/err", int'({p_ready, p_err}), 2);
    expect_eq("R8", "pass valid", int'(p_valid), int'(q_v));
    if (q_v) expect_eq("R8", "pass word", int'({p_data, p_port, p_sop, p_eop, p_empty}),
                       int'({q_data, q_port, q_sop, q_eop, 1'b0}));
  endtask

  task automatic model_step();
    bit take;
    take = in_valid && !mhold;
    q_v = in_valid; q_data = in_data; q_port = in_port; q_sop = in_sop; q_eop = in_eop;
    e_v = 0; e_err = 0; e_empty = 0; e_code = 0;
    if (mhold) begin
      e_v = 1; e_data = mhd; e_port = mhp; e_sop = 1; e_eop = mhe;
      e_err = 1; e_code = 2'd1; mopen[mhp] = !mhe; mhold = 0;
    end else if (take) begin
      e_v = 1; e_data = in_data; e_port = in_port; e_sop = in_sop; e_eop = in_eop;
      if (in_port < NP) begin
        if (!mopen[in_port]) begin
          if (!in_sop && !in_eop) begin e_sop = 1; e_err = 1; e_code = 2'd0; mopen[in_port] = 1; end
          else if (!in_sop && in_eop) begin e_v = 0; e_err = 1; e_code = 2'd3; end
          else mopen[in_port] = !in_eop;
        end else if (in_sop) begin
          e_data = '0; e_sop = 0; e_eop = 1; e_empty = 1; e_err = 1; e_code = 2'd2;
          mhold = 1; mhd = in_data; mhp = in_port; mhe = in_eop; mopen[in_port] = 0;
        end else if (in_eop) mopen[in_port] = 0;
      end
    end
    e_ready = !mhold;
  endtask

  task automatic send(bit v, int p, bit s, bit e, int d);
    bit was_ready;
    do begin
      @(negedge clk);
      compare();
      in_valid = v; in_port = 8'(p); in_sop = s; in_eop = e; in_data = DW'(d);
      was_ready = !mhold;
      model_step();
    end while (v && !was_ready);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    // R1: outputs idle and ready high while in reset
    expect_eq("R1", "reset valid/err", int'({out_valid, err_stb, p_valid}), 0);
    expect_eq("R1", "reset ready", int'(in_ready), 1);
    rst = 1'b0;
    foreach (mopen[i]) mopen[i] = 0;
    mhold = 0;
    model_step();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    send(1, 0, 1, 0, 'h0101);          // R2 normal start
    send(1, 0, 0, 0, 'h0102);
    send(1, 1, 1, 0, 'h1101);          // R6 interleave
    send(1, 0, 0, 1, 'h0103);
    send(1, 2, 0, 0, 'h2201);          // R3 missing start
    send(1, 2, 0, 1, 'h2202);
    send(1, 3, 0, 1, 'h3301);          // R5 lone end dropped
    send(1, 3, 0, 0, 'h3302);          // R5 port 3 still closed -> R3
    send(1, 3, 0, 1, 'h3303);
    send(1, 1, 1, 0, 'h1102);          // R4 repeated start with stall
    send(1, 1, 1, 1, 'h1103);          // R4 again, single-word restart
    send(1, 1, 0, 0, 'h1104);          // R6 port 1 closed after sop+eop -> R3
    send(1, 1, 0, 1, 'h1105);
    send(1, 5, 0, 1, 'h5501);          // R7 unchecked tag
    send(1, 4, 1, 1, 'h4401);
    send(1, 5, 0, 0, 'h5502);
    send(1, 0, 1, 1, 'h0104);          // R6 single-word packet
    send(1, 0, 1, 0, 'h0105);
    send(0, 0, 0, 0, 0);
    do_reset();                        // R1 clears open port 0
    send(1, 0, 0, 0, 'h0106);          // R1 -> missing start after reset
    send(1, 0, 0, 1, 'h0107);
    for (int i = 0; i < 4000; i++)
      send($urandom_range(0, 9) < 8, $urandom_range(0, 5),
           $urandom_range(0, 9) < 3, $urandom_range(0, 9) < 3, int'($urandom_range(0, 65535)));
    send(0, 0, 0, 0, 0);
    @(negedge clk);
    compare();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule